// File: doc/BRIEF.md
# Four-Mode Significand Rounding Unit

This block shortens a normalized binary significand to a narrower kept width. Alongside the significand it takes a sign bit and a sticky bit that stands for any nonzero bits already dropped further down. It applies one of four rounding rules, chosen by a 2-bit mode input. The result is registered once. Next to the rounded significand the block reports two flags. One is a carry that asks the exponent logic to add one. The other is an inexact flag that says some discarded information was nonzero.

Inside, the bits below the kept field are folded into a guard bit, a round bit and a sticky bit. A small decision stage combines these with the mode, the sign and the lowest kept bit to decide whether to add one to the magnitude. An incrementer then applies that decision. When the kept field is all ones, the incremented result does not fit. The field is then replaced by a leading one followed by zeros, and the carry is raised. Exponent arithmetic, normalization and special values are left to the neighbouring logic.

Top module: `round_unit`

## Requirements
- R1: With mode 2'b00 (nearest), the magnitude is incremented when the discarded part, sticky bit included, is more than half a unit of the last kept bit, and left alone when it is less.
- R2: With mode 2'b00, a discarded part exactly half a unit (guard bit 1, every lower bit and the sticky input 0) increments only when the lowest kept bit is 1, so the result always ends in 0.
- R3: With mode 2'b01 (toward minus infinity), the magnitude is incremented only when the sign is 1 and some discarded bit or the sticky input is nonzero.
- R4: With mode 2'b10 (toward plus infinity), the magnitude is incremented only when the sign is 0 and some discarded bit or the sticky input is nonzero.
- R5: With mode 2'b11 (toward zero), the output is the kept bits unchanged, whatever the sign.
- R6: When an increment overflows the kept field, the output is 1 followed by zeros and carry_o is 1; in every other case carry_o is 0.
- R7: inexact_o is 1 exactly when some discarded bit or the sticky input is nonzero, in every mode.
- R8: An input with all discarded bits and the sticky input zero comes out as its kept bits in every mode and for both signs.
- R9: Outputs appear one clock after a cycle with in_valid high. out_valid is high exactly in the cycle after in_valid. Data outputs hold while in_valid is low. Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operand is present this cycle |
| sign_i | input | 1 | Sign of the value, 1 for negative |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| sig_i | input | IN_W | Normalized significand, kept bits in the upper OUT_W positions |
| sticky_i | input | 1 | OR of nonzero bits already discarded below sig_i |
| out_valid | output | 1 | Registered result is valid |
| sig_o | output | OUT_W | Rounded significand |
| carry_o | output | 1 | Rounding overflowed; exponent must be incremented |
| inexact_o | output | 1 | Some discarded information was nonzero |

## Verification
The hardest situations to reach are the exact tie in nearest mode, which needs the sticky input low and the discarded bits to be exactly a guard one, and the increment of an all-ones kept field. Each of these occurs for only a few input patterns. The bench therefore runs a small configuration (8 bits in, 4 kept) through every normalized significand, both sticky values, both signs and all four modes. That sweep lands on every tie with both lowest-kept-bit values and on every carry-producing combination.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef struct packed {
        logic guard;
        logic round;
        logic sticky;
    } grs_t;

    function automatic logic any_lost(grs_t g);
        return g.guard | g.round | g.sticky;
    endfunction

    function automatic logic want_increment(rmode_e m, logic sign, logic lsb, grs_t g);
        logic inc;
        case (m)
            RM_NEAREST: inc = g.guard & (g.round | g.sticky | lsb);
            RM_DOWN:    inc = sign & any_lost(g);
            RM_UP:      inc = ~sign & any_lost(g);
            default:    inc = 1'b0;
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/rnd_grs_extract.sv
module rnd_grs_extract
    import rnd_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 4
) (
    input  logic [IN_W-1:0]  sig_i,
    input  logic             sticky_i,
    output logic [OUT_W-1:0] kept_o,
    output grs_t             grs_o
);
    localparam int DROP_W = IN_W - OUT_W;

    assign kept_o      = sig_i[IN_W-1:DROP_W];
    assign grs_o.guard = sig_i[DROP_W-1];
    assign grs_o.round = sig_i[DROP_W-2];

    generate
        if (DROP_W > 2) begin : g_low
            assign grs_o.sticky = (|sig_i[DROP_W-3:0]) | sticky_i;
        end else begin : g_nolow
            assign grs_o.sticky = sticky_i;
        end
    endgenerate
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  rmode_e mode_i,
    input  logic   sign_i,
    input  logic   lsb_i,
    input  grs_t   grs_i,
    output logic   inc_o,
    output logic   inexact_o
);
    assign inc_o     = want_increment(mode_i, sign_i, lsb_i, grs_i);
    assign inexact_o = any_lost(grs_i);
endmodule

// File: rtl/rnd_increment.sv
module rnd_increment #(
    parameter int OUT_W = 4
) (
    input  logic [OUT_W-1:0] kept_i,
    input  logic             inc_i,
    output logic [OUT_W-1:0] sig_o,
    output logic             carry_o
);
    logic [OUT_W:0] sum;

    always_comb begin
        sum = {1'b0, kept_i} + {{OUT_W{1'b0}}, inc_i};
        if (sum[OUT_W]) begin
            sig_o   = {1'b1, {(OUT_W-1){1'b0}}};
            carry_o = 1'b1;
        end else begin
            sig_o   = sum[OUT_W-1:0];
            carry_o = 1'b0;
        end
    end
endmodule

// File: rtl/round_unit.sv
module round_unit
    import rnd_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             sign_i,
    input  logic [1:0]       mode_i,
    input  logic [IN_W-1:0]  sig_i,
    input  logic             sticky_i,
    output logic             out_valid,
    output logic [OUT_W-1:0] sig_o,
    output logic             carry_o,
    output logic             inexact_o
);
    localparam logic [OUT_W-1:0] OVF_PATTERN = {1'b1, {(OUT_W-1){1'b0}}};

    rmode_e           mode;
    logic [OUT_W-1:0] kept;
    grs_t             grs;
    logic             inc;
    logic             lost;
    logic [OUT_W-1:0] rounded;
    logic             carry;

    assign mode = rmode_e'(mode_i);

    rnd_grs_extract #(.IN_W(IN_W), .OUT_W(OUT_W)) u_grs (
        .sig_i(sig_i), .sticky_i(sticky_i), .kept_o(kept), .grs_o(grs)
    );

    rnd_decide u_dec (
        .mode_i(mode), .sign_i(sign_i), .lsb_i(kept[0]), .grs_i(grs),
        .inc_o(inc), .inexact_o(lost)
    );

    rnd_increment #(.OUT_W(OUT_W)) u_inc (
        .kept_i(kept), .inc_i(inc), .sig_o(rounded), .carry_o(carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sig_o     <= '0;
            carry_o   <= 1'b0;
            inexact_o <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sig_o     <= rounded;
                carry_o   <= carry;
                inexact_o <= lost;
            end
        end
    end

    assert_carry_pattern_R6: assert property (@(posedge clk) disable iff (rst)
        carry_o |-> sig_o == OVF_PATTERN);
    assert_exact_no_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !inexact_o) |-> !carry_o);
    assert_trunc_no_inc_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == RM_ZERO) |-> !inc);
    assert_down_sign_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == RM_DOWN && !sign_i) |-> !inc);
    assert_up_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == RM_UP && sign_i) |-> !inc);
    assert_inc_needs_loss_R7: assert property (@(posedge clk) disable iff (rst)
        inc |-> lost);
    assert_tie_even_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == RM_NEAREST && inc && !carry) |-> !rounded[0] || grs.round || grs.sticky);
    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(sig_o));
endmodule

// File: tb/round_unit_test.sv
module round_unit_test;
    localparam int IN_W  = 8;
    localparam int OUT_W = 4;
    localparam int DW    = IN_W - OUT_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             sign_i = 1'b0;
    logic [1:0]       mode_i = 2'b00;
    logic [IN_W-1:0]  sig_i = '0;
    logic             sticky_i = 1'b0;
    logic             out_valid;
    logic [OUT_W-1:0] sig_o;
    logic             carry_o;
    logic             inexact_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    round_unit #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sign_i(sign_i),
        .mode_i(mode_i), .sig_i(sig_i), .sticky_i(sticky_i),
        .out_valid(out_valid), .sig_o(sig_o), .carry_o(carry_o),
        .inexact_o(inexact_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (sig=%0h sign=%0d mode=%0d sticky=%0d)",
                     tag, act, exp, sig_i, sign_i, mode_i, sticky_i);
        end
    endtask

    task automatic apply(input int s, input int sg, input int m, input int st);
        @(negedge clk);
        sig_i    = s[IN_W-1:0];
        sign_i   = sg[0];
        mode_i   = m[1:0];
        sticky_i = st[0];
        in_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_round(input int s, input int sg, input int m, input int st);
        int kept, rem, half, inc, sum, exp_sig, exp_c, nz;
        string tag;
        kept = s >> DW;
        rem  = s & ((1 << DW) - 1);
        half = 1 << (DW - 1);
        nz   = (rem != 0 || st != 0) ? 1 : 0;
        case (m)
            0: begin
                if (rem == half && st == 0) begin
                    inc = kept & 1; tag = "R2";
                end else begin
                    inc = (rem > half || (rem == half && st != 0)) ? 1 : 0; tag = "R1";
                end
            end
            1: begin inc = (sg != 0 && nz != 0) ? 1 : 0; tag = "R3"; end
            2: begin inc = (sg == 0 && nz != 0) ? 1 : 0; tag = "R4"; end
            default: begin inc = 0; tag = "R5"; end
        endcase
        if (nz == 0) tag = "R8";
        sum = kept + inc;
        if (sum == (1 << OUT_W)) begin
            exp_sig = 1 << (OUT_W - 1); exp_c = 1;
        end else begin
            exp_sig = sum; exp_c = 0;
        end
        check(tag, int'(sig_o), exp_sig);
        check("R6", int'(carry_o), exp_c);
        check("R7", int'(inexact_o), nz);
        check("R9", int'(out_valid), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check("R9", int'(out_valid), 0);
        check("R9", int'(sig_o), 0);
        check("R9", int'(carry_o), 0);
        check("R9", int'(inexact_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // R4 / R3: 1.0111 with three kept fraction bits
        apply(8'hB8, 0, 2, 0);
        check("R4", int'(sig_o), 4'hC);
        apply(8'hB8, 0, 1, 0);
        check("R3", int'(sig_o), 4'hB);

        // R6: all ones kept field pushed over
        apply(8'hFF, 0, 0, 0);
        check("R6", int'(sig_o), 8);
        check("R6", int'(carry_o), 1);

        // R9: idle cycle holds data, drops valid
        @(negedge clk);
        in_valid = 1'b0;
        sig_i = 8'h80;
        @(posedge clk);
        #1;
        check("R9", int'(out_valid), 0);
        check("R9", int'(sig_o), 8);

        // exhaustive sweep over normalized inputs
        for (int s = (1 << (IN_W - 1)); s < (1 << IN_W); s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    for (int st = 0; st < 2; st++) begin
                        apply(s, sg, m, st);
                        expect_round(s, sg, m, st);
                    end
                end
            end
        end

        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R9", int'(out_valid), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule